// File: doc/BRIEF.md
# Sticky Alarm Flag Interrupt Aggregator

This block gathers a vector of live, already-synchronized alarm inputs from a clock-monitoring device and turns them into sticky flags and a single active-low interrupt. Every clock edge at which an alarm bit is high sets its flag. The flag then holds until software clears it. Each flag has a mask bit. A flag with its mask bit at 0 pulls the registered interrupt output low.

The default vector is 16 bits wide. Bits [3:0] are the four loss-of-signal alarms and bits [7:4] are the four out-of-frequency alarms. Bits 8 to 15 are single-bit sources, in this order: loss of lock, holdover, calibration busy, crystal input loss of signal, reference loss, crystal error, bus timeout, system calibration. The alarm, flag and mask vectors all use this layout. Software reaches the block through a one-cycle register port. A 2-bit selector chooses the view: code 0 is the live alarms (read only), code 1 is the flags (write 0 to clear), code 2 is the mask (read/write) and code 3 is unused (reads zero). Reads are combinational from the selector.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset every flag is 0, every mask bit is 1 and `irq_n_o` is 1.
- R2: A flag bit becomes 1 at the first rising clock edge at which its alarm bit is 1.
- R3: A flag bit that is 1 stays 1 after its alarm returns to 0, until a clear write takes effect.
- R4: A write with selector code 1 clears every flag bit whose written data bit is 0 and whose alarm bit is 0 in that cycle.
- R5: If the alarm bit is 1 in the same cycle as a clear write, the flag is set or stays set. The set wins.
- R6: Writing 1 to a flag bit leaves that bit unchanged. Software cannot set a flag.
- R7: A write with selector code 2 replaces the whole mask with the written data at that clock edge.
- R8: `irq_n_o` is registered. It goes to 0 one clock edge after any bit has flag 1 and mask 0.
- R9: When the last unmasked pending flag is masked, `irq_n_o` returns to 1 one edge after the mask changes.
- R10: Selector code 0 reads the live alarm inputs and code 3 reads zero. Writes with code 0 or 3 change neither flags nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_i | input | 16 | Live alarm inputs, already synchronized |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| reg_sel_i | input | 2 | View select: 0 alarms, 1 flags, 2 mask, 3 unused |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for the selected view |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The hardest case to reach from the ports is a clear write that lands while the matching alarm is still high. Ordinary traffic makes this a coincidence, so the stimulus holds an alarm high and issues clear writes with only that bit zeroed in the data. It then drops the alarm and repeats the write, so both the blocked clear and the working clear are seen. The interrupt latency is covered the same way: a mask bit is opened and later closed over a pending flag. The random phase keeps alarms sparse and writes frequent, so that clears, masks and alarm rises collide often. A behavioural model is compared against the outputs on every cycle.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int DEF_LOS_BITS    = 4;
    localparam int DEF_OOF_BITS    = 4;
    localparam int DEF_SINGLE_BITS = 8;

    typedef enum logic [1:0] {
        SEL_ALARM = 2'd0,
        SEL_FLAG  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] alarm_i,
    input  logic [WIDTH-1:0] clr_req_i,
    output logic [WIDTH-1:0] flag_o
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic flag_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (alarm_i[g]) begin
                    flag_q <= 1'b1;
                end else if (clr_req_i[g]) begin
                    flag_q <= 1'b0;
                end
            end

            assign flag_o[g] = flag_q;

            // R2 R5
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                alarm_i[g] |=> flag_o[g]);

            // R3
            sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_o[g] && !clr_req_i[g]) |=> flag_o[g]);

            // R4
            clear_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_req_i[g] && !alarm_i[g]) |=> !flag_o[g]);

            // R6
            no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_o[g] && !alarm_i[g]) |=> !flag_o[g]);
        end
    endgenerate

endmodule

// File: rtl/mask_bank.sv
module mask_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] mask_o
);

    logic [WIDTH-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en_i) begin
            mask_q <= wr_data_i;
        end
    end

    assign mask_o = mask_q;

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mask_o == $past(wr_data_i)));

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_o));

endmodule

// File: rtl/irq_reduce.sv
module irq_reduce #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flag_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_n_o
);

    logic [WIDTH-1:0] live_term;
    logic             irq_n_q;

    always_comb begin
        live_term = flag_i & ~mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= ~(|live_term);
        end
    end

    assign irq_n_o = irq_n_q;

    // R8
    pending_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_i & ~mask_i)) |=> !irq_n_o);

    // R9
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_i) |=> irq_n_o);

endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
    import alarm_irq_pkg::*;
#(
    parameter int LOS_BITS    = DEF_LOS_BITS,
    parameter int OOF_BITS    = DEF_OOF_BITS,
    parameter int SINGLE_BITS = DEF_SINGLE_BITS
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [LOS_BITS+OOF_BITS+SINGLE_BITS-1:0] alarm_i,
    input  logic                                   wr_en_i,
    input  logic [1:0]                             reg_sel_i,
    input  logic [LOS_BITS+OOF_BITS+SINGLE_BITS-1:0] wr_data_i,
    output logic [LOS_BITS+OOF_BITS+SINGLE_BITS-1:0] rd_data_o,
    output logic                                   irq_n_o
);

    localparam int SRC_W = LOS_BITS + OOF_BITS + SINGLE_BITS;

    reg_sel_e          sel;
    logic              wr_flag;
    logic              wr_mask;
    logic [SRC_W-1:0]  clr_req;
    logic [SRC_W-1:0]  flag;
    logic [SRC_W-1:0]  mask;

    assign sel     = reg_sel_e'(reg_sel_i);
    assign wr_flag = wr_en_i && (sel == SEL_FLAG);
    assign wr_mask = wr_en_i && (sel == SEL_MASK);
    assign clr_req = {SRC_W{wr_flag}} & ~wr_data_i;

    sticky_flag_bank #(.WIDTH(SRC_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_i   (alarm_i),
        .clr_req_i (clr_req),
        .flag_o    (flag)
    );

    mask_bank #(.WIDTH(SRC_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_mask),
        .wr_data_i (wr_data_i),
        .mask_o    (mask)
    );

    irq_reduce #(.WIDTH(SRC_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_i  (flag),
        .mask_i  (mask),
        .irq_n_o (irq_n_o)
    );

    always_comb begin
        unique case (sel)
            SEL_ALARM: rd_data_o = alarm_i;
            SEL_FLAG:  rd_data_o = flag;
            SEL_MASK:  rd_data_o = mask;
            default:   rd_data_o = '0;
        endcase
    end

    // R10
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (sel != SEL_MASK)) |=> $stable(mask));

    // R10
    none_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (rd_data_o == '0));

endmodule

// File: tb/sim_alarm_irq_top.sv
module sim_alarm_irq_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] alarm = '0;
    logic         wr = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rd_data;
    logic         irq_n;

    int vectors = 0;
    int miscompares = 0;
    bit cmp_en = 1'b0;

    // behavioural reference state
    logic [W-1:0] m_flag;
    logic [W-1:0] m_mask;
    logic         m_irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_i   (alarm),
        .wr_en_i   (wr),
        .reg_sel_i (sel),
        .wr_data_i (wdata),
        .rd_data_o (rd_data),
        .irq_n_o   (irq_n)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic w, input logic [1:0] s,
                         input logic [W-1:0] d);
        @(posedge clk);
        #1;
        alarm = a;
        wr    = w;
        sel   = s;
        wdata = d;
    endtask

    // reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag  = '0;
            m_mask  = '1;
            m_irq_n = 1'b1;
        end else begin
            logic pend;
            pend = 1'b0;
            for (int i = 0; i < W; i++) begin
                if (m_flag[i] && !m_mask[i]) pend = 1'b1;
            end
            m_irq_n = !pend;
            for (int i = 0; i < W; i++) begin
                if (alarm[i]) m_flag[i] = 1'b1;
                else if (wr && sel == 2'd1 && !wdata[i]) m_flag[i] = 1'b0;
            end
            if (wr && sel == 2'd2) m_mask = wdata;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            case (sel)
                2'd0: chk("R10 live alarm view", rd_data, alarm);
                2'd1: chk("R3 flag view", rd_data, m_flag);
                2'd2: chk("R7 mask view", rd_data, m_mask);
                default: chk("R10 unused view", rd_data, '0);
            endcase
            chk("R8 irq model", {15'd0, irq_n}, {15'd0, m_irq_n});
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n  = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        drive('0, 0, 2'd1, '0);
        @(negedge clk);
        chk("R1 flags after reset", rd_data, 16'h0000);
        chk("R1 irq after reset", {15'd0, irq_n}, 16'h0001);
        drive('0, 0, 2'd2, '0);
        @(negedge clk);
        chk("R1 mask after reset", rd_data, 16'hFFFF);

        // R2 single-cycle alarm pulse on bit 3
        drive(16'h0008, 0, 2'd1, '0);
        drive('0, 0, 2'd1, '0);
        @(negedge clk);
        chk("R2 flag set by alarm", rd_data, 16'h0008);
        repeat (5) drive('0, 0, 2'd1, '0);
        @(negedge clk);
        chk("R3 flag held after alarm drop", rd_data, 16'h0008);

        // R5 clear attempt on bit 5 while its alarm is high
        drive(16'h0020, 1, 2'd1, 16'hFFDF);
        drive(16'h0020, 1, 2'd1, 16'hFFDF);
        drive('0, 0, 2'd1, '0);
        @(negedge clk);
        chk("R5 clear blocked by live alarm", rd_data, 16'h0028);

        // R4 clear after alarm drop
        drive('0, 1, 2'd1, 16'hFFDF);
        drive('0, 0, 2'd1, '0);
        @(negedge clk);
        chk("R4 clear with alarm low", rd_data, 16'h0008);

        // R6 writing ones sets nothing
        drive('0, 1, 2'd1, 16'hFFFF);
        drive('0, 0, 2'd1, '0);
        @(negedge clk);
        chk("R6 write ones no set", rd_data, 16'h0008);

        // R7 / R8 unmask bit 3
        drive('0, 1, 2'd2, 16'hFFF7);
        drive('0, 0, 2'd2, '0);
        @(negedge clk);
        chk("R7 mask written", rd_data, 16'hFFF7);
        chk("R8 irq one edge later still high", {15'd0, irq_n}, 16'h0001);
        drive('0, 0, 2'd2, '0);
        @(negedge clk);
        chk("R8 irq asserted", {15'd0, irq_n}, 16'h0000);

        // R9 mask it again
        drive('0, 1, 2'd2, 16'hFFFF);
        drive('0, 0, 2'd2, '0);
        @(negedge clk);
        chk("R9 irq still low before register", {15'd0, irq_n}, 16'h0000);
        drive('0, 0, 2'd2, '0);
        @(negedge clk);
        chk("R9 irq released", {15'd0, irq_n}, 16'h0001);

        // R10 writes to alarm and unused views
        drive('0, 1, 2'd0, 16'h0000);
        drive('0, 1, 2'd3, 16'h0000);
        drive('0, 0, 2'd1, '0);
        @(negedge clk);
        chk("R10 flags untouched by foreign write", rd_data, 16'h0008);
        drive('0, 0, 2'd2, '0);
        @(negedge clk);
        chk("R10 mask untouched by foreign write", rd_data, 16'hFFFF);
        drive('0, 0, 2'd3, '0);
        @(negedge clk);
        chk("R10 unused view reads zero", rd_data, 16'h0000);
        drive(16'h1234, 0, 2'd0, '0);
        @(negedge clk);
        chk("R10 live alarm read", rd_data, 16'h1234);

        // random collisions of alarms, clears and mask writes
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] a;
            logic [W-1:0] d;
            a = W'($urandom & $urandom & $urandom);
            d = W'($urandom | $urandom);
            drive(a, ($urandom % 3) == 0, 2'($urandom), d);
        end
        drive('0, 0, 2'd1, '0);
        @(negedge clk);

        summary();
        $finish;
    end

endmodule